// File: doc/BRIEF.md
# Two-View Row Merge Stage

This block takes two warped rows that describe the same intermediate viewpoint: one built from the left camera and one from the right. It combines them, position by position, into one merged row. Each incoming pixel carries a value and a flag that marks it as a hole, meaning the warp left no data there. At every position the stage does one of three things. If one side is a hole, it copies the pixel from the other side. If both sides are valid, it outputs their rounded mean. If both sides are holes, it passes a hole on, so that a later fill stage can deal with it.

Each of the two input sides writes into its own two-bank row buffer. The merged rows go into a third two-bank buffer, which the downstream stage drains. A producer can therefore fill one bank while the merge reads the other, and the merge can write one output bank while the consumer drains the other. This lets warping, merging and filling overlap in time.

A merged row only begins once a complete left row and a complete right row are both held. From then on, one pixel is merged on every clock.

Top module: `view_merge_stage`

## Requirements
- R1: After reset, both input sides report ready (`lv_ready`, `rv_ready` high) and no merged row is available (`mg_avail` low).
- R2: Where the left pixel is a hole (`lv_hole`=1) and the right pixel is not, the merged pixel equals the right value and its hole flag is 0.
- R3: Where the right pixel is a hole and the left pixel is not, the merged pixel equals the left value and its hole flag is 0.
- R4: Where neither pixel is a hole, the merged value is (left + right + 1) >> 1, computed on a sum one bit wider than the pixel. Examples: 255,255 gives 255; 0,1 gives 1. The hole flag is 0.
- R5: Where both pixels are holes, the merged hole flag is 1 and the merged value is 0.
- R6: No merging starts while only one side holds a complete row. `mg_avail` stays low however long that side waits.
- R7: When both banks of one input side hold unmerged rows, that side's ready is low. Writes presented while it is low are discarded and never show up in any merged row.
- R8: Merged pixel k of a row is built from input pixel k of the matching left and right rows. Rows leave in the order they were written.
- R9: With both rows complete and an output bank free, the merge takes exactly ROW_LEN cycles. `mg_avail` rises ROW_LEN clock edges after the edge that stores the last input pixel.
- R10: While both output banks hold unread rows, further complete input rows wait. They merge once a bank is drained, and they keep their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lv_wr | input | 1 | Store one left-side pixel |
| lv_pix | input | PIX_W | Left-side pixel value |
| lv_hole | input | 1 | Left-side pixel is a hole |
| lv_ready | output | 1 | Left side has a bank that can accept pixels |
| rv_wr | input | 1 | Store one right-side pixel |
| rv_pix | input | PIX_W | Right-side pixel value |
| rv_hole | input | 1 | Right-side pixel is a hole |
| rv_ready | output | 1 | Right side has a bank that can accept pixels |
| mg_rd | input | 1 | Consume the current merged pixel |
| mg_pix | output | PIX_W | Current merged pixel value |
| mg_hole | output | 1 | Current merged pixel is still a hole |
| mg_avail | output | 1 | A complete merged row is ready to read |

## Verification
The properties assume that a producer writes whole rows in pixel order and that the consumer drains whole rows. The ready signals are the only thing that limits writes, so the properties also hold when a write arrives while ready is low. The bench writes rows as complete bursts of ROW_LEN pixels and reads only after `mg_avail` is seen. It deliberately drives writes while ready is low, to exercise the discard path. The pixel patterns cover all four hole combinations, the extremes of the mean, and rows that back up in both input and output buffers.

// File: rtl/vmerge_pkg.sv
package vmerge_pkg;

   typedef enum logic [1:0] {
      MSEL_NONE  = 2'd0,
      MSEL_LEFT  = 2'd1,
      MSEL_RIGHT = 2'd2,
      MSEL_MEAN  = 2'd3
   } msel_e;

   function automatic msel_e pick_source(input logic left_hole, input logic right_hole);
      if (left_hole && right_hole) return MSEL_NONE;
      if (left_hole)               return MSEL_RIGHT;
      if (right_hole)              return MSEL_LEFT;
      return MSEL_MEAN;
   endfunction

endpackage

// File: rtl/row_pingpong.sv
module row_pingpong #(
   parameter int W     = 9,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic         wr_ready,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         rd_avail
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [W-1:0]  mem [2][DEPTH];
   logic [1:0]    full;
   logic          wr_bank, rd_bank;
   logic [AW-1:0] wr_idx, rd_idx;
   logic          do_wr, do_rd;

   assign wr_ready = ~full[wr_bank];
   assign rd_avail = full[rd_bank];
   assign rd_data  = mem[rd_bank][rd_idx];
   assign do_wr    = wr_en & wr_ready;
   assign do_rd    = rd_en & rd_avail;

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_bank][wr_idx] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_bank <= 1'b0;
         wr_idx  <= '0;
      end else if (do_wr) begin
         if (wr_idx == LAST) begin
            wr_idx  <= '0;
            wr_bank <= ~wr_bank;
         end else begin
            wr_idx <= wr_idx + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_bank <= 1'b0;
         rd_idx  <= '0;
      end else if (do_rd) begin
         if (rd_idx == LAST) begin
            rd_idx  <= '0;
            rd_bank <= ~rd_bank;
         end else begin
            rd_idx <= rd_idx + 1'b1;
         end
      end
   end

   for (genvar b = 0; b < 2; b++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)
            full[b] <= 1'b0;
         else if (do_wr && wr_idx == LAST && wr_bank == 1'(b))
            full[b] <= 1'b1;
         else if (do_rd && rd_idx == LAST && rd_bank == 1'(b))
            full[b] <= 1'b0;
      end
   end

endmodule

// File: rtl/pixel_merger.sv
module pixel_merger
   import vmerge_pkg::*;
#(
   parameter int PIX_W         = 8,
   parameter bit ROUND_HALF_UP = 1'b1
) (
   input  logic [PIX_W-1:0] l_pix,
   input  logic             l_hole,
   input  logic [PIX_W-1:0] r_pix,
   input  logic             r_hole,
   output logic [PIX_W-1:0] m_pix,
   output logic             m_hole
);
   localparam int SW = PIX_W + 1;

   logic [SW-1:0]    pair_sum;
   logic [PIX_W-1:0] mean;
   msel_e            sel;

   assign pair_sum = {1'b0, l_pix} + {1'b0, r_pix};
   assign sel      = pick_source(l_hole, r_hole);

   if (ROUND_HALF_UP) begin : g_round
      logic [SW-1:0] biased;
      assign biased = pair_sum + SW'(1);
      assign mean   = biased[SW-1:1];
   end else begin : g_trunc
      assign mean = pair_sum[SW-1:1];
   end

   always_comb begin
      m_hole = 1'b0;
      unique case (sel)
         MSEL_NONE: begin
            m_pix  = '0;
            m_hole = 1'b1;
         end
         MSEL_LEFT:  m_pix = l_pix;
         MSEL_RIGHT: m_pix = r_pix;
         default:    m_pix = mean;
      endcase
   end

endmodule

// File: rtl/view_merge_stage.sv
module view_merge_stage #(
   parameter int PIX_W         = 8,
   parameter int ROW_LEN       = 16,
   parameter bit ROUND_HALF_UP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lv_wr,
   input  logic [PIX_W-1:0] lv_pix,
   input  logic             lv_hole,
   output logic             lv_ready,
   input  logic             rv_wr,
   input  logic [PIX_W-1:0] rv_pix,
   input  logic             rv_hole,
   output logic             rv_ready,
   input  logic             mg_rd,
   output logic [PIX_W-1:0] mg_pix,
   output logic             mg_hole,
   output logic             mg_avail
);
   localparam int EW = PIX_W + 1;

   if (PIX_W < 1) begin : g_bad_width
      $error("view_merge_stage: PIX_W must be at least 1");
   end
   if (ROW_LEN < 2) begin : g_bad_len
      $error("view_merge_stage: ROW_LEN must be at least 2");
   end

   logic [EW-1:0]    l_ent, r_ent, m_ent, o_ent;
   logic             l_avail, r_avail, o_ready;
   logic             fire;
   logic [PIX_W-1:0] m_pix;
   logic             m_hole;

   assign fire = l_avail & r_avail & o_ready;

   row_pingpong #(.W(EW), .DEPTH(ROW_LEN)) u_left (
      .clk(clk), .rst_n(rst_n),
      .wr_en(lv_wr), .wr_data({lv_hole, lv_pix}), .wr_ready(lv_ready),
      .rd_en(fire), .rd_data(l_ent), .rd_avail(l_avail));

   row_pingpong #(.W(EW), .DEPTH(ROW_LEN)) u_right (
      .clk(clk), .rst_n(rst_n),
      .wr_en(rv_wr), .wr_data({rv_hole, rv_pix}), .wr_ready(rv_ready),
      .rd_en(fire), .rd_data(r_ent), .rd_avail(r_avail));

   pixel_merger #(.PIX_W(PIX_W), .ROUND_HALF_UP(ROUND_HALF_UP)) u_merge (
      .l_pix(l_ent[PIX_W-1:0]), .l_hole(l_ent[PIX_W]),
      .r_pix(r_ent[PIX_W-1:0]), .r_hole(r_ent[PIX_W]),
      .m_pix(m_pix), .m_hole(m_hole));

   assign m_ent = {m_hole, m_pix};

   row_pingpong #(.W(EW), .DEPTH(ROW_LEN)) u_out (
      .clk(clk), .rst_n(rst_n),
      .wr_en(fire), .wr_data(m_ent), .wr_ready(o_ready),
      .rd_en(mg_rd), .rd_data(o_ent), .rd_avail(mg_avail));

   assign mg_pix  = o_ent[PIX_W-1:0];
   assign mg_hole = o_ent[PIX_W];

endmodule

// File: rtl/vmerge_checker.sv
module vmerge_checker #(
   parameter int PIX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lv_ready,
   input logic             rv_ready,
   input logic             mg_avail,
   input logic             mg_rd,
   input logic             fire,
   input logic [PIX_W-1:0] l_pix,
   input logic             l_hole,
   input logic [PIX_W-1:0] r_pix,
   input logic             r_hole,
   input logic [PIX_W-1:0] m_pix,
   input logic             m_hole
);
   logic [PIX_W-1:0] lo_v, hi_v;
   assign lo_v = (l_pix < r_pix) ? l_pix : r_pix;
   assign hi_v = (l_pix < r_pix) ? r_pix : l_pix;

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (lv_ready && rv_ready && !mg_avail));

   assert_copy_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && l_hole && !r_hole) |-> (!m_hole && m_pix == r_pix));

   assert_copy_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && r_hole && !l_hole) |-> (!m_hole && m_pix == l_pix));

   assert_mean_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !l_hole && !r_hole) |-> (!m_hole && m_pix >= lo_v && m_pix <= hi_v));

   assert_double_hole_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && l_hole && r_hole) |-> (m_hole && m_pix == '0));

   assert_left_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!lv_ready && !fire) |=> !lv_ready);

   assert_right_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rv_ready && !fire) |=> !rv_ready);

   assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mg_avail && !mg_rd) |=> mg_avail);

endmodule

bind view_merge_stage vmerge_checker #(.PIX_W(PIX_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .lv_ready(lv_ready), .rv_ready(rv_ready),
   .mg_avail(mg_avail), .mg_rd(mg_rd), .fire(fire),
   .l_pix(l_ent[PIX_W-1:0]), .l_hole(l_ent[PIX_W]),
   .r_pix(r_ent[PIX_W-1:0]), .r_hole(r_ent[PIX_W]),
   .m_pix(m_pix), .m_hole(m_hole));

// File: tb/sim_view_merge_stage.sv
module sim_view_merge_stage;
   localparam int N = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lv_wr = 1'b0, rv_wr = 1'b0, mg_rd = 1'b0;
   logic [7:0] lv_pix = '0, rv_pix = '0;
   logic       lv_hole = 1'b0, rv_hole = 1'b0;
   logic       lv_ready, rv_ready, mg_hole, mg_avail;
   logic [7:0] mg_pix;

   int n_checks = 0;
   int n_fail   = 0;

   logic [7:0] lpx [3][N];
   logic [7:0] rpx [3][N];
   logic       lhl [3][N];
   logic       rhl [3][N];

   always #2 clk = ~clk;

   view_merge_stage #(.PIX_W(8), .ROW_LEN(N), .ROUND_HALF_UP(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .lv_wr(lv_wr), .lv_pix(lv_pix), .lv_hole(lv_hole), .lv_ready(lv_ready),
      .rv_wr(rv_wr), .rv_pix(rv_pix), .rv_hole(rv_hole), .rv_ready(rv_ready),
      .mg_rd(mg_rd), .mg_pix(mg_pix), .mg_hole(mg_hole), .mg_avail(mg_avail));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   task automatic write_left(input int r);
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         lv_wr = 1'b1; lv_pix = lpx[r][i]; lv_hole = lhl[r][i];
      end
      @(negedge clk);
      lv_wr = 1'b0;
   endtask

   task automatic write_right(input int r);
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         rv_wr = 1'b1; rv_pix = rpx[r][i]; rv_hole = rhl[r][i];
      end
      @(negedge clk);
      rv_wr = 1'b0;
   endtask

   task automatic wait_avail(input string req);
      int k = 0;
      while (!mg_avail && k < 200) begin
         @(negedge clk);
         k++;
      end
      check(mg_avail == 1'b1, req, int'(mg_avail), 1);
   endtask

   task automatic read_check(input int r);
      wait_avail("R8 row ready");
      for (int i = 0; i < N; i++) begin
         logic [7:0] ep;
         logic       eh;
         string      tag;
         @(negedge clk);
         if (lhl[r][i] && rhl[r][i]) begin
            ep = 8'd0; eh = 1'b1; tag = "R5 R8";
         end else if (lhl[r][i]) begin
            ep = rpx[r][i]; eh = 1'b0; tag = "R2 R8";
         end else if (rhl[r][i]) begin
            ep = lpx[r][i]; eh = 1'b0; tag = "R3 R8";
         end else begin
            ep = 8'((({1'b0, lpx[r][i]} + {1'b0, rpx[r][i]}) + 9'd1) >> 1);
            eh = 1'b0; tag = "R4 R8";
         end
         check(mg_avail && mg_pix == ep && mg_hole == eh, tag,
               int'({mg_avail, mg_hole, mg_pix}), int'({1'b1, eh, ep}));
         mg_rd = 1'b1;
      end
      @(negedge clk);
      mg_rd = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(lv_ready && rv_ready && !mg_avail, "R1 reset state",
            int'({lv_ready, rv_ready, mg_avail}), 6);
   endtask

   task automatic t_latency_and_cases();
      int cnt = 0;
      write_left(0);
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         rv_wr = 1'b1; rv_pix = rpx[0][i]; rv_hole = rhl[0][i];
      end
      @(negedge clk);
      rv_wr = 1'b0;
      check(!mg_avail, "R9 not yet", int'(mg_avail), 0);
      while (!mg_avail && cnt < 100) begin
         @(negedge clk);
         cnt++;
      end
      check(cnt == N, "R9 merge cycles", cnt, N);
      read_check(0);
   endtask

   task automatic t_one_side();
      write_left(1);
      repeat (3 * N) @(negedge clk);
      check(!mg_avail, "R6 left only", int'(mg_avail), 0);
      check(rv_ready, "R6 right still empty", int'(rv_ready), 1);
      write_right(1);
      read_check(1);
   endtask

   task automatic t_backpressure();
      write_left(1);
      write_left(2);
      check(!lv_ready, "R7 left full", int'(lv_ready), 0);
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         lv_wr = 1'b1; lv_pix = 8'hAA; lv_hole = 1'b0;
      end
      @(negedge clk);
      lv_wr = 1'b0;
      check(!lv_ready, "R7 still full", int'(lv_ready), 0);
      write_right(1);
      write_right(2);
      repeat (2 * N) @(negedge clk);
      write_left(0);
      write_right(0);
      repeat (3 * N) @(negedge clk);
      check(mg_avail, "R10 output held", int'(mg_avail), 1);
      read_check(1);
      read_check(2);
      read_check(0);
      repeat (2) @(negedge clk);
      check(!mg_avail, "R10 drained", int'(mg_avail), 0);
   endtask

   initial begin
      #(4 * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      lpx[0][0] = 8'd9;   lhl[0][0] = 1'b1; rpx[0][0] = 8'd77;  rhl[0][0] = 1'b0;
      lpx[0][1] = 8'd200; lhl[0][1] = 1'b0; rpx[0][1] = 8'd3;   rhl[0][1] = 1'b1;
      lpx[0][2] = 8'd255; lhl[0][2] = 1'b0; rpx[0][2] = 8'd255; rhl[0][2] = 1'b0;
      lpx[0][3] = 8'd0;   lhl[0][3] = 1'b0; rpx[0][3] = 8'd1;   rhl[0][3] = 1'b0;
      lpx[0][4] = 8'd40;  lhl[0][4] = 1'b1; rpx[0][4] = 8'd60;  rhl[0][4] = 1'b1;
      lpx[0][5] = 8'd10;  lhl[0][5] = 1'b0; rpx[0][5] = 8'd13;  rhl[0][5] = 1'b0;
      lpx[0][6] = 8'd254; lhl[0][6] = 1'b0; rpx[0][6] = 8'd255; rhl[0][6] = 1'b0;
      lpx[0][7] = 8'd100; lhl[0][7] = 1'b0; rpx[0][7] = 8'd50;  rhl[0][7] = 1'b0;
      for (int r = 1; r < 3; r++) begin
         for (int i = 0; i < N; i++) begin
            lpx[r][i] = 8'(r * 37 + i * 29 + 5);
            rpx[r][i] = 8'(r * 11 + i * 53 + 200);
            lhl[r][i] = ((i + r) % 3) == 0;
            rhl[r][i] = ((i * r) % 4) == 1;
         end
      end
      t_reset();
      t_latency_and_cases();
      t_one_side();
      t_backpressure();
      finish_run();
   end

endmodule